// File: doc/BRIEF.md
# Ready and Reset Synchronizer

This block brings two asynchronous signals into the processor clock domain. The first is a ready request from a wait-state source that may run on a different clock. The second is a raw active-low power-on reset, typically from an RC network. The ready path has a capture stage on the rising clock edge and an output stage on the falling clock edge. Because of this, the ready output changes only while the clock is low and holds steady across every rising edge, where the processor samples it.

A static strap selects the synchronization depth. With the strap low, the request passes through the rising-edge stage and then the falling-edge stage. With the strap high, the request goes straight to the falling-edge stage, for a source that already runs on this clock. In both modes the delay can only grow, never shrink. A normally-not-ready source therefore gets, at worst, one extra wait state.

The reset output is cleared at once when the raw reset falls. It is released only on a rising clock edge, after a parameterized number of edges. This ensures that every downstream state register leaves reset on the same edge.

Top module: `rdy_rst_sync`

## Requirements
- R1: The capture stage samples `rdy_req` on each rising clock edge while `rst_sync_n` is high.
- R2: `rdy_sync` updates only on falling clock edges, so its value just before a rising edge equals its value just after that edge.
- R3: With `bypass_strap` = 1 (one stage), `rdy_sync` during a clock-low phase equals the value `rdy_req` had at the falling edge that opened that phase. A request driven after a rising edge appears at the next falling edge, about half a cycle later.
- R4: With `bypass_strap` = 0 (two stages), a request driven after a rising edge is captured at the next rising edge and appears on `rdy_sync` at the falling edge after that, about one cycle later than in R3.
- R5: A low level on `rst_raw_n` drives `rst_sync_n` low immediately, without waiting for a clock edge.
- R6: After `rst_raw_n` rises, `rst_sync_n` rises exactly at the RST_STAGES-th rising clock edge (default 2), and never at any other time within the cycle.
- R7: While `rst_sync_n` is low, `rdy_sync` is 0 (not ready) whatever `rdy_req` is. After release, `rdy_sync` stays 0 until the first falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_raw_n | input | 1 | Raw asynchronous active-low reset |
| rdy_req | input | 1 | Asynchronous ready request, 1 = ready |
| bypass_strap | input | 1 | 1 = output stage only, 0 = both stages |
| rdy_sync | output | 1 | Synchronized ready, registered on the falling edge |
| rst_sync_n | output | 1 | Synchronized active-low reset |

## Verification
The bench changes the request two time units after a rising edge. It reads `rdy_sync` two units after the next falling edge. The expected value there is the bit just driven in one-stage mode, and the bit driven one cycle earlier in two-stage mode. Every 8-bit request pattern is swept in both modes. Around each following rising edge, the output is read once just before and once just after the edge to confirm it holds. Reset is released at every offset inside the cycle. The bench expects `rst_sync_n` still low one unit after the first rising edge and high one unit after the second, and it timestamps each rise against the rising-edge phase.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  // Strap encoding for the ready path depth
  typedef enum logic {
    SYNC_TWO_STAGE = 1'b0,
    SYNC_ONE_STAGE = 1'b1
  } sync_mode_e;

  localparam int unsigned RRS_RST_STAGES_DEF  = 2;
  localparam int unsigned RRS_RISE_STAGES_DEF = 1;

endpackage

// File: rtl/rrs_reset_sync.sv
module rrs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_raw_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_raw_n) begin
    if (!rst_raw_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

  // R6
  rst_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_raw_n)
    $rose(rst_sync_n) |-> $past(rst_raw_n));

endmodule

// File: rtl/rrs_rise_chain.sv
module rrs_rise_chain #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d[0] = din;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

  // R1
  rise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stage_q[0] == $past(din)));

endmodule

// File: rtl/rrs_fall_stage.sv
module rrs_fall_stage
  import rrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_direct,
  input  logic       req_synced,
  input  sync_mode_e mode,
  output logic       rdy_q
);

  logic rdy_d;

  always_comb begin
    if (mode == SYNC_ONE_STAGE) begin
      rdy_d = req_direct;
    end else begin
      rdy_d = req_synced;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
    end
  end

  // R3
  one_stage_path_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == SYNC_ONE_STAGE) |=> (rdy_q == $past(req_direct)));

  // R4
  two_stage_path_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (mode == SYNC_TWO_STAGE) |=> (rdy_q == $past(req_synced)));

endmodule

// File: rtl/rdy_rst_sync.sv
module rdy_rst_sync
  import rrs_pkg::*;
#(
  parameter int unsigned RST_STAGES  = RRS_RST_STAGES_DEF,
  parameter int unsigned RISE_STAGES = RRS_RISE_STAGES_DEF
) (
  input  logic clk,
  input  logic rst_raw_n,
  input  logic rdy_req,
  input  logic bypass_strap,
  output logic rdy_sync,
  output logic rst_sync_n
);

  logic       rst_int_n;
  logic       req_rise;
  sync_mode_e mode;

  assign mode = sync_mode_e'(bypass_strap);

  rrs_reset_sync #(
    .STAGES(RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_raw_n (rst_raw_n),
    .rst_sync_n(rst_int_n)
  );

  rrs_rise_chain #(
    .STAGES(RISE_STAGES)
  ) u_rise (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (rdy_req),
    .dout (req_rise)
  );

  rrs_fall_stage u_fall (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_direct(rdy_req),
    .req_synced(req_rise),
    .mode      (mode),
    .rdy_q     (rdy_sync)
  );

  assign rst_sync_n = rst_int_n;

  // R7
  not_ready_in_reset_chk: assert property (@(negedge clk) disable iff (rst_int_n)
    !rst_int_n |-> !rdy_sync);

endmodule

// File: tb/rdy_rst_sync_tb.sv
`timescale 1ns/1ps
module rdy_rst_sync_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RSTN       = 2;

  logic clk;
  logic rst_raw_n;
  logic rdy_req;
  logic bypass_strap;
  logic rdy_sync;
  logic rst_sync_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  rdy_rst_sync u_dut (
    .clk         (clk),
    .rst_raw_n   (rst_raw_n),
    .rdy_req     (rdy_req),
    .bypass_strap(bypass_strap),
    .rdy_sync    (rdy_sync),
    .rst_sync_n  (rst_sync_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // R6: every release of the synchronized reset lands on a rising edge
  always @(posedge rst_sync_n) begin
    chk(($time % CLK_PERIOD) == CLK_PERIOD/2, "R6 edge",
        int'($time % CLK_PERIOD), CLK_PERIOD/2);
  end

  task automatic sweep(input logic strap);
    logic prev;
    logic b_val;
    bypass_strap = strap;
    rdy_req = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    prev = 1'b0;
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic bitv;
        logic expv;
        bitv = p[k];
        rdy_req = bitv;
        expv = strap ? bitv : prev;
        @(negedge clk);
        #2;
        chk(rdy_sync == expv, strap ? "R3" : "R4", rdy_sync, expv);
        #2;
        b_val = rdy_sync;
        @(posedge clk);
        #1;
        chk(rdy_sync == b_val, "R2", rdy_sync, b_val);
        #1;
        prev = bitv;
      end
    end
  endtask

  task automatic reset_pulse(input int d);
    @(posedge clk);
    #(d);
    rdy_req = 1'b1;
    rst_raw_n = 1'b0;
    #1;
    chk(rst_sync_n == 1'b0, "R5", rst_sync_n, 0);
    chk(rdy_sync == 1'b0, "R7", rdy_sync, 0);
    repeat (2) @(posedge clk);
    #(d);
    rst_raw_n = 1'b1;
    for (int e = 1; e < RSTN; e++) begin
      @(posedge clk);
      #1;
      chk(rst_sync_n == 1'b0, "R6 early", rst_sync_n, 0);
    end
    @(posedge clk);
    #1;
    chk(rst_sync_n == 1'b1, "R6 release", rst_sync_n, 1);
    chk(rdy_sync == 1'b0, "R7 hold", rdy_sync, 0);
    @(negedge clk);
    #1;
    chk(rdy_sync == 1'b1, "R7 first", rdy_sync, 1);
  endtask

  initial begin
    rst_raw_n = 1'b0;
    rdy_req = 1'b1;
    bypass_strap = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(rst_sync_n == 1'b0, "R5 reset state", rst_sync_n, 0);
    chk(rdy_sync == 1'b0, "R7 reset state", rdy_sync, 0);
    #1;
    rst_raw_n = 1'b1;
    repeat (RSTN + 1) @(posedge clk);
    #1;
    chk(rst_sync_n == 1'b1, "R6 initial", rst_sync_n, 1);
    sweep(1'b1);
    sweep(1'b0);
    bypass_strap = 1'b1;
    for (int d = 1; d < CLK_PERIOD; d++) begin
      reset_pulse(d);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule